// File: doc/BRIEF.md
# Processor Status Register with Stack Byte Formatting

This block keeps the condition and mode flags of an 8-bit accumulator CPU and turns them into the byte that is written to the stack whenever the flags are saved. Six flags have storage: carry, zero, interrupt disable, decimal, overflow and negative. The ALU sends per-flag write strobes with new values. The sequencer can set or clear any flag directly, or reload the flags from a byte read off the stack. It asks for a save by presenting a push request tagged with the reason for the save.

Bit positions 4 and 5 have no storage. In a saved byte, bit 5 is always high. Bit 4 tells a software save (explicit push-status or break) apart from a hardware interrupt. On a reload, both positions are discarded. The live status byte shows bit 5 high and bit 4 low.

The save path is a valid/ready stream toward the stack writer. A push request is accepted in a cycle where `psh_valid` and `psh_ready` are both high. `psh_ready` is high whenever the output register is empty or is being drained that cycle. While `stk_valid` is high and `stk_ready` is low, the output byte is held unchanged and no new push is accepted. The flag-side inputs are plain strobes with no handshake.

Top module: `psr_status`

## Requirements
- R1: After reset, the interrupt-disable flag reads 1, `stk_valid` is 0 and `psh_ready` is 1; the other flags keep no defined reset value.
- R2: `status_out` places negative at bit 7, overflow at bit 6, decimal at bit 3, interrupt disable at bit 2, zero at bit 1 and carry at bit 0; bit 5 always reads 1 and bit 4 always reads 0.
- R3: The 6-bit strobe and value vectors use index 0 carry, 1 zero, 2 interrupt disable, 3 decimal, 4 overflow, 5 negative. A flag whose `alu_upd` bit is high takes the matching `alu_val` bit at the next clock; all other flags keep their value.
- R4: `set_cmd` and `clr_cmd` force the indexed flags to 1 or 0 at the next clock and override an ALU update. When both are high for one flag, set wins.
- R5: `pull_en` loads each flag from its `status_out` bit position in `pull_byte`, ignores bits 5 and 4, and overrides set, clear and ALU updates in the same cycle.
- R6: An accepted push puts the flags into `stk_data` at the R2 positions, as they stood before that cycle's updates, with bit 5 set to 1.
- R7: `psh_cause` encodes 0 as the explicit push-status instruction, 1 as break, 2 as maskable interrupt and 3 as non-maskable interrupt. Bit 4 of the pushed byte is 1 for codes 0 and 1 and 0 for codes 2 and 3.
- R8: An accepted push with cause 1, 2 or 3 sets interrupt disable at the same clock, overriding any pull, clear or ALU write to that flag. A cause-0 push leaves the flag alone.
- R9: `psh_ready` equals `!stk_valid || stk_ready`. While `stk_valid && !stk_ready`, `stk_data` and `stk_valid` stay put, and a pending push has no effect on any flag. `stk_valid` falls after a transfer with no new push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd | input | 6 | Per-flag ALU write strobes |
| alu_val | input | 6 | Per-flag ALU values |
| set_cmd | input | 6 | Per-flag set commands |
| clr_cmd | input | 6 | Per-flag clear commands |
| pull_en | input | 1 | Reload flags from stack byte |
| pull_byte | input | 8 | Stack byte for reload |
| psh_valid | input | 1 | Push request |
| psh_cause | input | 2 | Push cause code |
| psh_ready | output | 1 | Push request can be accepted |
| stk_valid | output | 1 | Formatted push byte is valid |
| stk_data | output | 8 | Formatted push byte |
| stk_ready | input | 1 | Stack writer takes the byte |
| status_out | output | 8 | Live status byte |

## Verification
The hardest case to reach is an interrupt-cause push that arrives while the stack writer is stalled. It must leave interrupt disable alone until the push is actually accepted, and then capture the flag's earlier value. The bench first fills the output register with `stk_ready` low. It then offers a maskable-interrupt push together with a clear of interrupt disable, and checks that the flag reads 0 and the held byte is unchanged. Finally it raises `stk_ready` and checks that the new byte carries the cleared flag while the live flag goes high.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int NFLAG  = 6;
  localparam int BYTE_W = 8;
  localparam int POS_SRC = 4;
  localparam int POS_ONE = 5;
  localparam int FL_I = 2;

  typedef enum logic [1:0] {
    CAUSE_SWPUSH = 2'd0,
    CAUSE_BREAK  = 2'd1,
    CAUSE_IRQ    = 2'd2,
    CAUSE_NMI    = 2'd3
  } push_cause_e;

  // flag index -> byte bit position (skips the two unstored positions)
  function automatic int flag_pos(input int idx);
    return (idx < POS_SRC) ? idx : idx + 2;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_flags(input logic [NFLAG-1:0] f,
                                                    input logic src_bit);
    logic [BYTE_W-1:0] b;
    b = '0;
    for (int i = 0; i < NFLAG; i++) b[flag_pos(i)] = f[i];
    b[POS_ONE] = 1'b1;
    b[POS_SRC] = src_bit;
    return b;
  endfunction
endpackage

// File: rtl/psr_flag_cell.sv
module psr_flag_cell #(
  parameter bit HAS_RST = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alu_we,
  input  logic alu_d,
  input  logic set_c,
  input  logic clr_c,
  input  logic pull_we,
  input  logic pull_d,
  input  logic force_set,
  output logic q
);
  logic nxt;

  // priority, lowest first: ALU, clear, set, pull, forced set
  always_comb begin
    nxt = q;
    if (alu_we)    nxt = alu_d;
    if (clr_c)     nxt = 1'b0;
    if (set_c)     nxt = 1'b1;
    if (pull_we)   nxt = pull_d;
    if (force_set) nxt = 1'b1;
  end

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt;
      end
    end else begin : g_norst
      // no reset value; updates are held off while reset is asserted
      always_ff @(posedge clk) begin
        if (rst_n) q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/psr_flag_bank.sv
module psr_flag_bank
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  alu_upd,
  input  logic [NFLAG-1:0]  alu_val,
  input  logic [NFLAG-1:0]  set_cmd,
  input  logic [NFLAG-1:0]  clr_cmd,
  input  logic              pull_en,
  input  logic [BYTE_W-1:0] pull_byte,
  input  logic              take_int,
  output logic [NFLAG-1:0]  flags
);
  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      localparam bit IS_I = (i == FL_I);
      psr_flag_cell #(
        .HAS_RST (IS_I),
        .RST_VAL (1'b1)
      ) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_we    (alu_upd[i]),
        .alu_d     (alu_val[i]),
        .set_c     (set_cmd[i]),
        .clr_c     (clr_cmd[i]),
        .pull_we   (pull_en),
        .pull_d    (pull_byte[flag_pos(i)]),
        .force_set (IS_I ? take_int : 1'b0),
        .q         (flags[i])
      );
    end
  endgenerate
endmodule

// File: rtl/psr_push_fmt.sv
module psr_push_fmt
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  flags,
  input  logic              psh_valid,
  input  logic [1:0]        psh_cause,
  output logic              psh_ready,
  output logic              take_int,
  output logic              stk_valid,
  output logic [BYTE_W-1:0] stk_data,
  input  logic              stk_ready
);
  push_cause_e cause;
  logic        accept;
  logic        sw_src;

  assign cause     = push_cause_e'(psh_cause);
  assign psh_ready = !stk_valid || stk_ready;
  assign accept    = psh_valid && psh_ready;
  assign sw_src    = (cause == CAUSE_SWPUSH) || (cause == CAUSE_BREAK);
  assign take_int  = accept && (cause != CAUSE_SWPUSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stk_valid <= 1'b0;
    else if (accept)    stk_valid <= 1'b1;
    else if (stk_ready) stk_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) stk_data <= pack_flags(flags, sw_src);
  end
endmodule

// File: rtl/psr_status.sv
module psr_status
  import psr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] alu_upd,
  input  logic [5:0] alu_val,
  input  logic [5:0] set_cmd,
  input  logic [5:0] clr_cmd,
  input  logic       pull_en,
  input  logic [7:0] pull_byte,
  input  logic       psh_valid,
  input  logic [1:0] psh_cause,
  output logic       psh_ready,
  output logic       stk_valid,
  output logic [7:0] stk_data,
  input  logic       stk_ready,
  output logic [7:0] status_out
);
  logic [NFLAG-1:0] flags;
  logic             take_int;

  psr_flag_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_upd   (alu_upd),
    .alu_val   (alu_val),
    .set_cmd   (set_cmd),
    .clr_cmd   (clr_cmd),
    .pull_en   (pull_en),
    .pull_byte (pull_byte),
    .take_int  (take_int),
    .flags     (flags)
  );

  psr_push_fmt u_push (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .psh_valid (psh_valid),
    .psh_cause (psh_cause),
    .psh_ready (psh_ready),
    .take_int  (take_int),
    .stk_valid (stk_valid),
    .stk_data  (stk_data),
    .stk_ready (stk_ready)
  );

  assign status_out = pack_flags(flags, 1'b0);
endmodule

// File: rtl/psr_status_chk.sv
module psr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       psh_valid,
  input logic [1:0] psh_cause,
  input logic       psh_ready,
  input logic       stk_valid,
  input logic [7:0] stk_data,
  input logic       stk_ready,
  input logic [7:0] status_out
);
  a_r2_live_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[5] && !status_out[4]);

  a_r6_push_bit5_set: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid |-> stk_data[5]);

  a_r6_push_prior_idis: assert property (@(posedge clk) disable iff (!rst_n)
    (psh_valid && psh_ready) |=> (stk_data[2] == $past(status_out[2])));

  a_r7_sw_cause_bit4: assert property (@(posedge clk) disable iff (!rst_n)
    (psh_valid && psh_ready && !psh_cause[1]) |=> stk_data[4]);

  a_r7_hw_cause_bit4: assert property (@(posedge clk) disable iff (!rst_n)
    (psh_valid && psh_ready && psh_cause[1]) |=> !stk_data[4]);

  a_r8_int_sets_idis: assert property (@(posedge clk) disable iff (!rst_n)
    (psh_valid && psh_ready && (psh_cause != 2'd0)) |=> status_out[2]);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_data)));

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    psh_ready == (!stk_valid || stk_ready));
endmodule

bind psr_status psr_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .psh_valid  (psh_valid),
  .psh_cause  (psh_cause),
  .psh_ready  (psh_ready),
  .stk_valid  (stk_valid),
  .stk_data   (stk_data),
  .stk_ready  (stk_ready),
  .status_out (status_out)
);

// File: tb/tb_psr_status.sv
`timescale 1ns/1ps
module tb_psr_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] alu_upd = '0, alu_val = '0, set_cmd = '0, clr_cmd = '0;
  logic       pull_en = 1'b0;
  logic [7:0] pull_byte = '0;
  logic       psh_valid = 1'b0;
  logic [1:0] psh_cause = '0;
  logic       psh_ready, stk_valid, stk_ready = 1'b1;
  logic [7:0] stk_data, status_out;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  psr_status dut (.*);

  // {alu_upd, alu_val, set_cmd, clr_cmd, pull_en, pull_byte, expected status}
  localparam int NV = 11;
  localparam logic [40:0] VEC [NV] = '{
    {6'b000000, 6'b000000, 6'b000000, 6'b000000, 1'b1, 8'h00, 8'h20},
    {6'b000000, 6'b000000, 6'b000000, 6'b000000, 1'b1, 8'hFF, 8'hEF},
    {6'b000000, 6'b000000, 6'b000000, 6'b000000, 1'b1, 8'h30, 8'h20},
    {6'b100011, 6'b100001, 6'b000000, 6'b000000, 1'b0, 8'h00, 8'hA1},
    {6'b000000, 6'b000000, 6'b010000, 6'b000000, 1'b0, 8'h00, 8'hE1},
    {6'b000000, 6'b000000, 6'b000000, 6'b100001, 1'b0, 8'h00, 8'h60},
    {6'b000000, 6'b000000, 6'b001000, 6'b001000, 1'b0, 8'h00, 8'h68},
    {6'b010010, 6'b000010, 6'b000000, 6'b000010, 1'b0, 8'h00, 8'h28},
    {6'b000100, 6'b000000, 6'b000100, 6'b000000, 1'b0, 8'h00, 8'h2C},
    {6'b000000, 6'b000000, 6'b111111, 6'b000000, 1'b1, 8'h83, 8'hA3},
    {6'b111111, 6'b111111, 6'b000000, 6'b000000, 1'b1, 8'h00, 8'h20}
  };
  localparam string VTAG [NV] = '{"R5", "R5", "R5", "R3", "R4", "R4",
                                  "R4", "R4", "R4", "R5", "R5"};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_upd = '0; alu_val = '0; set_cmd = '0; clr_cmd = '0;
    pull_en = 1'b0; pull_byte = '0; psh_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 idis", {7'd0, status_out[2]}, 8'h01);
    check("R1 stk_valid", {7'd0, stk_valid}, 8'h00);
    check("R1 psh_ready", {7'd0, psh_ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      {alu_upd, alu_val, set_cmd, clr_cmd, pull_en, pull_byte} = VEC[v][40:8];
      @(negedge clk);
      check(VTAG[v], status_out, VEC[v][7:0]);
      check("R2 fixed bits", {6'd0, status_out[5:4]}, 8'h02);
      idle();
    end

    // load a known state
    pull_en = 1'b1; pull_byte = 8'hC3;
    @(negedge clk); idle();
    check("R5 pull C3", status_out, 8'hE3);

    // explicit push-status: bits 4 and 5 both set, I unchanged
    psh_valid = 1'b1; psh_cause = 2'd0;
    @(negedge clk); idle();
    check("R6 R7 php byte", stk_data, 8'hF3);
    check("R9 valid after push", {7'd0, stk_valid}, 8'h01);
    check("R8 php keeps I", status_out, 8'hE3);

    @(negedge clk);
    check("R9 valid drops", {7'd0, stk_valid}, 8'h00);

    // maskable interrupt push
    psh_valid = 1'b1; psh_cause = 2'd2;
    @(negedge clk); idle();
    check("R7 irq byte", stk_data, 8'hE3);
    check("R8 irq sets I", status_out, 8'hE7);

    // NMI with simultaneous pull of zero: I forced
    psh_valid = 1'b1; psh_cause = 2'd3; pull_en = 1'b1; pull_byte = 8'h00;
    @(negedge clk); idle();
    check("R7 nmi byte", stk_data, 8'hE7);
    check("R8 nmi over pull", status_out, 8'h24);

    // break with clear of I: I still forced, bit 4 set
    psh_valid = 1'b1; psh_cause = 2'd1; clr_cmd = 6'b000100;
    @(negedge clk); idle();
    check("R7 brk byte", stk_data, 8'h34);
    check("R8 brk over clear", status_out, 8'h24);

    // stalled writer: IRQ offered, not accepted, clear of I takes effect
    stk_ready = 1'b0;
    psh_valid = 1'b1; psh_cause = 2'd2; clr_cmd = 6'b000100;
    #1;
    check("R9 ready low on stall", {7'd0, psh_ready}, 8'h00);
    @(negedge clk);
    clr_cmd = '0;
    check("R9 held data", stk_data, 8'h34);
    check("R9 held valid", {7'd0, stk_valid}, 8'h01);
    check("R9 no I set while stalled", status_out, 8'h20);

    // writer drains; pending IRQ now accepted with the earlier I value
    stk_ready = 1'b1;
    @(negedge clk); idle();
    check("R6 irq after stall byte", stk_data, 8'h20);
    check("R8 irq after stall", status_out, 8'h24);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule